// File: doc/BRIEF.md
# Weekly Minute Alarm Comparator

This block watches a running calendar and raises an interrupt when the current time reaches a programmed alarm. The alarm is given as a BCD minute, a BCD hour and a seven-bit set of weekdays. Each bit of that set stands for one weekday. Because the day is picked from a weekly set and not from a date, an alarm can never lie more than seven days ahead. The calendar supplies its current BCD minute, BCD hour and weekday number, together with a strobe that marks the start of each new minute. The comparison takes place only on that strobe, so an alarm has a resolution of one whole minute. It fires at second zero of the matching minute.

Software programs the block through a small register port with a shared address bus. A write takes effect at the clock edge. A read returns data combinationally from the address bus. A match that occurs while the alarm is enabled sets a sticky flag. That flag stays set until software writes a one to clear it. The interrupt output is the flag gated by the enable bit. Writing zero to the control register therefore silences the interrupt at once.

Top module: `wk_alarm_cmp`

## Requirements
- R1: After reset, every register reads zero (enable, flag, alarm minute, alarm hour, weekday set) and `irq` is low.
- R2: Register map, by address: 0 is control, with bit 0 as the alarm enable. 1 is status, with bit 0 as the flag; writing 1 to this bit clears the flag. 2 is the alarm minute in BCD, bits 6:0. 3 is the alarm hour in BCD, bits 5:0. 4 is the weekday set, where bit n selects weekday n (0 to 6). Bits outside each field are dropped on write and read back as zero. Addresses 5 to 7 read zero.
- R3: On a minute event, the flag is set at that clock edge if all of the following hold: the enable is 1, `curMin` equals the alarm minute, `curHour` equals the alarm hour, and the bit of the weekday set selected by `curDay` is 1. The flag is readable, and `irq` is high, in the cycle after that edge.
- R4: A difference in the minute, in the hour, or in the selected weekday bit leaves the flag at 0. A `curDay` value of 7 never matches.
- R5: A match that occurs while the enable is 0 does not set the flag, and enabling the alarm afterwards does not set it either.
- R6: Once set, the flag holds until a status write with bit 0 equal to 1. A status write with bit 0 equal to 0 has no effect.
- R7: `irq` equals the flag ANDed with the enable. After a control write of 0, `irq` is low from the next cycle while the flag keeps its value. Re-enabling the alarm raises `irq` again if the flag is still set.
- R8: A minute event is the rising edge of `minTick`. A strobe held high for several cycles gives one event, so once the flag is cleared while the strobe is still high it is not set again until `minTick` next rises.
- R9: When a flag clear and a flag-setting match land on the same clock edge, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 3 | Register address for write and read |
| regWdata | input | 8 | Register write data |
| regRdata | output | 8 | Register read data for `regAddr` |
| minTick | input | 1 | Minute-boundary strobe from the calendar |
| curMin | input | 7 | Current minute, BCD |
| curHour | input | 6 | Current hour, BCD |
| curDay | input | 3 | Current weekday number, 0 to 6 |
| irq | output | 1 | Alarm interrupt |

## Verification
The hardest cases to reach from the ports are the ones that turn on exact edge alignment. The first is a minute strobe held high across many cycles while software clears the flag partway through. The second is a clear write arriving on the very edge where a match sets the flag. For the first case, the bench raises `minTick` and keeps it high, performs the status clear inside that window, and confirms that the flag stays low until the strobe falls and rises again. For the second case, the bench places the status write and the strobe rise on the same falling-edge slot, so both reach the block at one rising edge.

// File: rtl/wk_alarm_pkg.sv
package wk_alarm_pkg;

  localparam int unsigned ADDR_W = 3;

  localparam logic [ADDR_W-1:0] ADDR_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_STAT = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_MIN  = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_HOUR = 3'd3;
  localparam logic [ADDR_W-1:0] ADDR_DAYS = 3'd4;

  // Strobes from the control half to the datapath half
  typedef struct packed {
    logic wrEn;     // control register write
    logic wrMin;    // alarm minute write
    logic wrHour;   // alarm hour write
    logic wrMask;   // weekday set write
    logic clrFlag;  // write-one-to-clear on the flag
    logic tickEvt;  // one-cycle minute event
  } ctlStrb_t;

endpackage

// File: rtl/wk_alarm_ctl.sv
module wk_alarm_ctl
  import wk_alarm_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  input  logic              minTick,
  output ctlStrb_t          strb
);

  logic tickPrev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tickPrev <= 1'b0;
    else        tickPrev <= minTick;
  end

  always_comb begin
    strb         = '0;
    strb.tickEvt = minTick & ~tickPrev;
    if (regWe) begin
      unique case (regAddr)
        ADDR_CTRL: strb.wrEn    = 1'b1;
        ADDR_STAT: strb.clrFlag = regWdata[0];
        ADDR_MIN:  strb.wrMin   = 1'b1;
        ADDR_HOUR: strb.wrHour  = 1'b1;
        ADDR_DAYS: strb.wrMask  = 1'b1;
        default:   ;
      endcase
    end
  end

  // R8: an event never repeats on back-to-back cycles
  p_single_event_r8: assert property (@(posedge clk) disable iff (!rst_n)
    strb.tickEvt |=> !strb.tickEvt);

endmodule

// File: rtl/wk_alarm_dp.sv
module wk_alarm_dp
  import wk_alarm_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned MIN_W  = 7,
  parameter int unsigned HOUR_W = 6,
  parameter int unsigned DAYS   = 7,
  localparam int unsigned DAY_W = $clog2(DAYS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctlStrb_t          strb,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  input  logic [MIN_W-1:0]  curMin,
  input  logic [HOUR_W-1:0] curHour,
  input  logic [DAY_W-1:0]  curDay,
  output logic [DATA_W-1:0] regRdata,
  output logic              irq
);

  logic [MIN_W-1:0]  almMin;
  logic [HOUR_W-1:0] almHour;
  logic [DAYS-1:0]   almMask;
  logic              almEn;
  logic              flag;
  logic [DAYS-1:0]   dayHit;
  logic              hit;
  logic              setFlag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      almMin  <= '0;
      almHour <= '0;
      almMask <= '0;
      almEn   <= 1'b0;
    end else begin
      if (strb.wrMin)  almMin  <= regWdata[MIN_W-1:0];
      if (strb.wrHour) almHour <= regWdata[HOUR_W-1:0];
      if (strb.wrMask) almMask <= regWdata[DAYS-1:0];
      if (strb.wrEn)   almEn   <= regWdata[0];
    end
  end

  for (genvar d = 0; d < DAYS; d++) begin : g_day
    assign dayHit[d] = almMask[d] && (curDay == DAY_W'(d));
  end

  assign hit     = (curMin == almMin) && (curHour == almHour) && (|dayHit);
  assign setFlag = strb.tickEvt && hit && almEn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            flag <= 1'b0;
    else if (setFlag)      flag <= 1'b1;
    else if (strb.clrFlag) flag <= 1'b0;
  end

  assign irq = flag & almEn;

  always_comb begin
    unique case (regAddr)
      ADDR_CTRL: regRdata = DATA_W'(almEn);
      ADDR_STAT: regRdata = DATA_W'(flag);
      ADDR_MIN:  regRdata = DATA_W'(almMin);
      ADDR_HOUR: regRdata = DATA_W'(almHour);
      ADDR_DAYS: regRdata = DATA_W'(almMask);
      default:   regRdata = '0;
    endcase
  end

  // R3: a flag rise traces back to an enabled minute event
  p_rise_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(strb.tickEvt && almEn));

  // R5: a disabled alarm cannot raise the flag
  p_disabled_no_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!almEn && !flag && !strb.wrEn) |=> !flag);

  // R6: the flag holds without a clear
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !strb.clrFlag) |=> flag);

  // R6: a clear with no competing event drops the flag
  p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.clrFlag && !strb.tickEvt) |=> !flag);

  // R7: disabling silences the interrupt on the next cycle
  p_irq_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.wrEn && !regWdata[0]) |=> !irq);

  // R9: set wins over a simultaneous clear
  p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.clrFlag && strb.tickEvt && hit && almEn) |=> flag);

endmodule

// File: rtl/wk_alarm_cmp.sv
module wk_alarm_cmp
  import wk_alarm_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned MIN_W  = 7,
  parameter int unsigned HOUR_W = 6,
  parameter int unsigned DAYS   = 7
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     regWe,
  input  logic [ADDR_W-1:0]        regAddr,
  input  logic [DATA_W-1:0]        regWdata,
  output logic [DATA_W-1:0]        regRdata,
  input  logic                     minTick,
  input  logic [MIN_W-1:0]         curMin,
  input  logic [HOUR_W-1:0]        curHour,
  input  logic [$clog2(DAYS)-1:0]  curDay,
  output logic                     irq
);

  ctlStrb_t strb;

  wk_alarm_ctl #(.DATA_W(DATA_W)) u_ctl (
    .clk      (clk),
    .rst_n    (rst_n),
    .regWe    (regWe),
    .regAddr  (regAddr),
    .regWdata (regWdata),
    .minTick  (minTick),
    .strb     (strb)
  );

  wk_alarm_dp #(
    .DATA_W (DATA_W),
    .MIN_W  (MIN_W),
    .HOUR_W (HOUR_W),
    .DAYS   (DAYS)
  ) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .strb     (strb),
    .regAddr  (regAddr),
    .regWdata (regWdata),
    .curMin   (curMin),
    .curHour  (curHour),
    .curDay   (curDay),
    .regRdata (regRdata),
    .irq      (irq)
  );

endmodule

// File: tb/wk_alarm_cmp_tb.sv
module wk_alarm_cmp_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       regWe = 1'b0;
  logic [2:0] regAddr = '0;
  logic [7:0] regWdata = '0;
  logic [7:0] regRdata;
  logic       minTick = 1'b0;
  logic [6:0] curMin = '0;
  logic [5:0] curHour = '0;
  logic [2:0] curDay = '0;
  logic       irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  wk_alarm_cmp u_dut (
    .clk(clk), .rst_n(rst_n), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .minTick(minTick),
    .curMin(curMin), .curHour(curHour), .curDay(curDay), .irq(irq)
  );

  // alMin alHour mask curMin curHour curDay en expFlag
  localparam logic [63:0] VEC [8] = '{
    64'h30_12_08_30_12_03_01_01,   // R3 exact match
    64'h31_12_08_30_12_03_01_00,   // R4 minute differs
    64'h30_11_08_30_12_03_01_00,   // R4 hour differs
    64'h30_12_08_30_12_02_01_00,   // R4 weekday bit clear
    64'h45_07_7F_45_07_06_01_01,   // R3 several days selected
    64'h30_12_08_30_12_03_00_00,   // R5 disabled
    64'h00_00_7F_00_00_07_01_00,   // R4 weekday 7
    64'h59_23_01_59_23_00_01_01    // R3 top of range
  };

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdata;
  endtask

  task automatic pulse();
    @(negedge clk); minTick = 1'b1;
    @(negedge clk); minTick = 1'b0;
  endtask

  task automatic setCal(logic [6:0] m, logic [5:0] h, logic [2:0] d);
    curMin = m; curHour = h; curDay = d;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), v); check("R1 register reset", v, 8'h00);
    end
    check("R1 irq reset", {7'd0, irq}, 8'h00);

    // R2 field widths and unused addresses
    wr(3'd2, 8'hFF); rd(3'd2, v); check("R2 minute width", v, 8'h7F);
    wr(3'd3, 8'hFF); rd(3'd3, v); check("R2 hour width", v, 8'h3F);
    wr(3'd4, 8'hFF); rd(3'd4, v); check("R2 weekday width", v, 8'h7F);
    wr(3'd0, 8'hFE); rd(3'd0, v); check("R2 enable bit only", v, 8'h00);
    wr(3'd5, 8'hFF); rd(3'd5, v); check("R2 unused address", v, 8'h00);

    // Vector table: R3 R4 R5
    for (int i = 0; i < 8; i++) begin
      logic [63:0] e;
      e = VEC[i];
      wr(3'd0, 8'h00);
      wr(3'd1, 8'h01);
      wr(3'd2, e[63:56]);
      wr(3'd3, e[55:48]);
      wr(3'd4, e[47:40]);
      wr(3'd0, e[15:8]);
      setCal(e[38:32], e[29:24], e[18:16]);
      pulse();
      rd(3'd1, v); check("R3/R4/R5 vector flag", v, e[7:0]);
      check("R3/R4/R5 vector irq", {7'd0, irq}, e[7:0] & e[15:8]);
      if (e[15:8] == 8'h00) begin
        wr(3'd0, 8'h01);
        rd(3'd1, v); check("R5 no late flag", v, 8'h00);
      end
    end

    // R6 hold and clear semantics
    wr(3'd0, 8'h01); wr(3'd2, 8'h10); wr(3'd3, 8'h08); wr(3'd4, 8'h04);
    setCal(7'h10, 6'h08, 3'd2);
    pulse();
    repeat (5) @(negedge clk);
    rd(3'd1, v); check("R6 flag holds", v, 8'h01);
    wr(3'd1, 8'h00); rd(3'd1, v); check("R6 write zero ignored", v, 8'h01);
    wr(3'd1, 8'h01); rd(3'd1, v); check("R6 clear", v, 8'h00);

    // R7 enable gating
    pulse();
    check("R7 irq raised", {7'd0, irq}, 8'h01);
    wr(3'd0, 8'h00);
    check("R7 irq off after disable", {7'd0, irq}, 8'h00);
    rd(3'd1, v); check("R7 flag kept", v, 8'h01);
    wr(3'd0, 8'h01);
    check("R7 irq back on enable", {7'd0, irq}, 8'h01);

    // R8 held strobe gives one event
    wr(3'd1, 8'h01);
    @(negedge clk); minTick = 1'b1;
    @(negedge clk);
    rd(3'd1, v); check("R8 first event sets", v, 8'h01);
    wr(3'd1, 8'h01);
    repeat (4) @(negedge clk);
    rd(3'd1, v); check("R8 held strobe no refire", v, 8'h00);
    @(negedge clk); minTick = 1'b0;
    repeat (2) @(negedge clk);
    rd(3'd1, v); check("R8 still clear after fall", v, 8'h00);
    pulse();
    rd(3'd1, v); check("R8 new rise sets", v, 8'h01);

    // R9 clear and set on the same edge
    @(negedge clk);
    minTick = 1'b1; regWe = 1'b1; regAddr = 3'd1; regWdata = 8'h01;
    @(negedge clk);
    minTick = 1'b0; regWe = 1'b0;
    rd(3'd1, v); check("R9 set wins", v, 8'h01);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule